// File: doc/BRIEF.md
# IO address translation table walker

This block turns 32-bit device DMA addresses into physical addresses. A device presents an address and a read/write flag; the block checks that translation is on and that the address lies inside the mapped window. It then looks up the page in a translation table in memory, using one 64-bit read over a request/acknowledge port. It returns either the physical address or a fault code. The window always ends at the top of the 32-bit space, and a 3-bit size code in the control register sets how large it is.

Software programs three write-only registers: control, table base and flush. The block keeps the last valid translation in a one-entry cache, so repeated accesses to the same page skip the memory read. Writing any of the three registers drops that cached entry. Only one translation is in flight at a time. The request-ready output stays low while a table read is pending. Pages are always 8 KiB.

Top module: `iotlb_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_req` are 0.
- R2: Control register (reg_addr 0) bit 0 enables translation. While it is 0, every request gets fault code 1 and issues no memory read.
- R3: With size code n in control bits 18:16, the window base is 0xFFFFFFFF shifted left by n+23, truncated to 32 bits. The window runs up to 0xFFFFFFFF. An address below the base gets fault code 2 and issues no memory read.
- R4: On a miss, the read address is {base[42:13], 13'b0} + ((addr − window base) >> 13) × 8. The base register is reg_addr 1, and its low 13 bits are ignored. `mem_req` and `mem_addr` hold steady until `mem_ack`.
- R5: An entry whose bit 63 is 0 gives fault code 3.
- R6: A write to a page whose entry bit 1 is 0 gives fault code 4. A read of that page succeeds.
- R7: A successful response gives code 0 and `rsp_pa` = {entry[42:13], addr[12:0]}. Entry bits 61, 60, 59, 12:7 and 4 have no effect.
- R8: For a request that needs no read, `rsp_valid` is 1 in the cycle after acceptance. For a miss, it is 1 in the cycle after the cycle in which `mem_ack` is sampled.
- R9: `req_ready` is 0 from the acceptance of a miss until its response.
- R10: A request in the window whose page equals the cached page gets its answer from the cache, with no memory read.
- R11: Any write to control, base or flush (reg_addr 2) empties the cache. Control bits 1 (diagnostic) and 2 (large page) have no effect on translation.
- R12: Only entries with bit 63 set are cached. A second access to an invalid page reads memory again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 control, 1 table base, 2 flush |
| reg_wdata | input | 64 | Register write data |
| req_valid | input | 1 | Device request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Device address |
| req_write | input | 1 | 1 for a device write |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_code | output | 3 | 0 ok, 1 disabled, 2 outside window, 3 invalid, 4 write-protected |
| rsp_pa | output | 43 | Translated physical address |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 43 | Table entry address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 64 | Table entry |

## Verification
Results that need no read (disabled, outside the window, cache hit) are due exactly one cycle after the accepting edge. The bench counts falling edges from acceptance and expects `rsp_valid` on the first one. For a miss, the bench's memory model picks a random delay of d cycles before it acknowledges. The response is then due d+2 falling edges after acceptance, with `req_ready` already low at the first. The bench counts table reads between request and response to tell hits from misses.

// File: rtl/iotlb_walker.sv
module iotlb_walker #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 43,
  parameter int PG_SH = 13,
  parameter int ENT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [63:0]      reg_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_addr,
  input  logic             req_write,
  output logic             rsp_valid,
  output logic [2:0]       rsp_code,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_ack,
  input  logic [ENT_W-1:0] mem_rdata
);
  localparam int PPN_W  = PA_W - PG_SH;
  localparam int VPN_W  = VA_W - PG_SH;
  localparam int MIN_SH = PG_SH + 10;
  localparam int V_BIT  = ENT_W - 1;
  localparam int W_BIT  = 1;
  localparam logic [2:0] C_OK = 3'd0, C_DIS = 3'd1, C_WIN = 3'd2, C_INV = 3'd3, C_WP = 3'd4;

  logic             en_q, diag_q, pg64_q;
  logic [2:0]       size_q;
  logic [PPN_W-1:0] base_q;
  logic             busy;
  logic             cache_v, cache_w;
  logic [VPN_W-1:0] cache_vpn;
  logic [PPN_W-1:0] cache_ppn;
  logic [PG_SH-1:0] pend_off;
  logic [VPN_W-1:0] pend_vpn;
  logic             pend_wr;

  logic [5:0]      win_sh;
  logic [VA_W-1:0] win_base, win_off;
  logic            accept, in_win, hit;
  logic [PA_W-1:0] walk_addr;

  assign win_sh    = 6'(size_q) + 6'(MIN_SH);
  assign win_base  = {VA_W{1'b1}} << win_sh;
  assign win_off   = req_addr - win_base;
  assign in_win    = req_addr >= win_base;
  assign hit       = cache_v && (cache_vpn == req_addr[VA_W-1:PG_SH]);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign walk_addr = {base_q, {PG_SH{1'b0}}} + PA_W'({win_off[VA_W-1:PG_SH], 3'b000});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; diag_q <= 1'b0; pg64_q <= 1'b0; size_q <= '0; base_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == 2'd0) begin
        en_q   <= reg_wdata[0];
        diag_q <= reg_wdata[1];
        pg64_q <= reg_wdata[2];
        size_q <= reg_wdata[18:16];
      end else if (reg_addr == 2'd1) begin
        base_q <= reg_wdata[PA_W-1:PG_SH];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; mem_req <= 1'b0; mem_addr <= '0;
      rsp_valid <= 1'b0; rsp_code <= C_OK; rsp_pa <= '0;
      cache_v <= 1'b0; cache_w <= 1'b0; cache_vpn <= '0; cache_ppn <= '0;
      pend_off <= '0; pend_vpn <= '0; pend_wr <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        if (!en_q) begin
          rsp_valid <= 1'b1; rsp_code <= C_DIS; rsp_pa <= '0;
        end else if (!in_win) begin
          rsp_valid <= 1'b1; rsp_code <= C_WIN; rsp_pa <= '0;
        end else if (hit) begin
          rsp_valid <= 1'b1;
          rsp_code  <= (req_write && !cache_w) ? C_WP : C_OK;
          rsp_pa    <= {cache_ppn, req_addr[PG_SH-1:0]};
        end else begin
          busy     <= 1'b1;
          mem_req  <= 1'b1;
          mem_addr <= walk_addr;
          pend_off <= req_addr[PG_SH-1:0];
          pend_vpn <= req_addr[VA_W-1:PG_SH];
          pend_wr  <= req_write;
        end
      end
      if (busy && mem_ack) begin
        busy      <= 1'b0;
        mem_req   <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_pa    <= {mem_rdata[PA_W-1:PG_SH], pend_off};
        if (!mem_rdata[V_BIT])                 rsp_code <= C_INV;
        else if (pend_wr && !mem_rdata[W_BIT]) rsp_code <= C_WP;
        else                                   rsp_code <= C_OK;
        if (mem_rdata[V_BIT]) begin
          cache_v   <= 1'b1;
          cache_w   <= mem_rdata[W_BIT];
          cache_vpn <= pend_vpn;
          cache_ppn <= mem_rdata[PA_W-1:PG_SH];
        end
      end
      if (reg_wr) cache_v <= 1'b0;
    end
  end

  assert_fetch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  assert_busy_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);
  assert_off_nofetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !en_q |=> !mem_req && rsp_valid && rsp_code == C_DIS);
  assert_below_win_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && en_q && (req_addr < win_base) |=> !mem_req && rsp_valid && rsp_code == C_WIN);
  assert_rsp_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready) || $past(mem_req && mem_ack));
  assert_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !cache_v);
  assert_inv_nocache_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mem_ack && !mem_rdata[V_BIT] && !cache_v |=> !cache_v);
endmodule

// File: tb/iotlb_walker_tb.sv
module iotlb_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic [2:0]  rsp_code;
  logic [42:0] rsp_pa;
  logic        mem_req;
  logic [42:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  iotlb_walker u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_pa(rsp_pa),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  int n_chk = 0, n_fail = 0;
  int fetch_cnt = 0, last_d = 0;
  logic [42:0] last_maddr = '0;

  bit          m_en = 0;
  logic [2:0]  m_size = 0;
  logic [29:0] m_base = 0;
  bit          mc_v = 0;
  logic [18:0] mc_vpn = 0;
  logic [63:0] mc_ent = 0;

  function automatic logic [63:0] entry_of(logic [42:0] a);
    logic [31:0] h;
    h = (a[31:0] ^ {a[42:32], 21'h0}) * 32'h9E3779B1;
    h = h ^ (h >> 15);
    h = h * 32'h85EBCA6B;
    h = h ^ (h >> 13);
    return {(h[31:30] != 2'b00), h[19:0], h[29:0], h[12:0]};
  endfunction

  function automatic logic [31:0] wbase(logic [2:0] n);
    return 32'hFFFFFFFF << (n + 23);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin : responder
    int cnt;
    bit busy;
    busy = 0; cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        busy = 0;
      end else if (mem_req) begin
        if (!busy) begin
          busy = 1;
          cnt = $urandom % 4;
          last_d = cnt;
        end
        if (cnt == 0) begin
          mem_ack = 1'b1;
          mem_rdata = entry_of(mem_addr);
          last_maddr = mem_addr;
          fetch_cnt++;
        end else cnt--;
      end
    end
  end

  task automatic wreg(logic [1:0] a, logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 2'd0) begin m_en = d[0]; m_size = d[18:16]; end
    if (a == 2'd1) m_base = d[42:13];
    mc_v = 0;
  endtask

  task automatic xlat(logic [31:0] addr, bit wr, string tag);
    logic [31:0] wb;
    logic [63:0] ent;
    logic [42:0] maddr;
    logic [2:0]  ecode;
    bit          fetch;
    int          f0, cyc;
    wb = wbase(m_size);
    fetch = 0; ent = '0; maddr = '0;
    if (!m_en) ecode = 3'd1;
    else if (addr < wb) ecode = 3'd2;
    else begin
      if (mc_v && mc_vpn == addr[31:13]) ent = mc_ent;
      else begin
        fetch = 1;
        maddr = {m_base, 13'b0} + 43'({((addr - wb) >> 13), 3'b000});
        ent = entry_of(maddr);
        if (ent[63]) begin mc_v = 1; mc_vpn = addr[31:13]; mc_ent = ent; end
      end
      ecode = !ent[63] ? 3'd3 : (wr && !ent[1]) ? 3'd4 : 3'd0;
    end
    @(negedge clk);
    f0 = fetch_cnt;
    req_valid = 1'b1; req_addr = addr; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    if (fetch) chk(!req_ready, {tag, " R9 ready low"}, 64'(req_ready), 0);
    while (!rsp_valid && cyc < 12) begin
      @(negedge clk);
      cyc++;
    end
    chk(rsp_valid == 1'b1, {tag, " R8 response seen"}, 64'(rsp_valid), 1);
    chk(cyc == (fetch ? last_d + 2 : 1), {tag, " R8 latency"}, 64'(cyc), 64'(fetch ? last_d + 2 : 1));
    chk((fetch_cnt - f0) == (fetch ? 1 : 0), {tag, " R10 fetch count"}, 64'(fetch_cnt - f0), 64'(fetch));
    if (fetch) chk(last_maddr == maddr, {tag, " R4 fetch addr"}, 64'(last_maddr), 64'(maddr));
    chk(rsp_code == ecode, {tag, " R2/R3/R5/R6 code"}, 64'(rsp_code), 64'(ecode));
    if (ecode == 3'd0)
      chk(rsp_pa == {ent[42:13], addr[12:0]}, {tag, " R7 pa"}, 64'(rsp_pa), 64'({ent[42:13], addr[12:0]}));
  endtask

  function automatic logic [31:0] find_page(bit want_valid, bit want_w, logic [31:0] start);
    logic [31:0] a;
    logic [63:0] e;
    a = start;
    for (int i = 0; i < 1000; i++) begin
      e = entry_of({m_base, 13'b0} + 43'({((a - wbase(m_size)) >> 13), 3'b000}));
      if (e[63] == want_valid && (!want_valid || e[1] == want_w)) return a;
      a = a + 32'h2000;
    end
    return start;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] a, prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready", 64'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 0);
    chk(mem_req == 1'b0, "R1 mem_req", 64'(mem_req), 0);

    xlat(32'hFFF00000, 0, "R2 disabled");
    wreg(2'd1, 64'h0000_0010_0002_2345);
    wreg(2'd0, 64'h1);
    xlat(32'hFF7FFFFF, 0, "R3 below base n0");
    xlat(32'hFF800000, 0, "R3 first slot");
    xlat(32'hFFFFFFFF, 0, "R3 last slot");
    xlat(32'hFFFFE123, 1, "R10 hit same page");
    wreg(2'd2, 64'h0);
    xlat(32'hFFFFE000, 0, "R11 flush forces miss");
    wreg(2'd0, 64'h7);
    xlat(32'hFFFFE004, 0, "R11 ctrl write, diag/pg64 set");
    wreg(2'd1, 64'h0000_0004_0000_1FFF);
    xlat(32'hFFFFE008, 0, "R11 base write");
    a = find_page(0, 0, 32'hFF900000);
    xlat(a, 0, "R5 invalid");
    xlat(a | 32'h40, 0, "R12 invalid refetch");
    a = find_page(1, 0, 32'hFFA00000);
    xlat(a, 1, "R6 write protected");
    xlat(a | 32'h10, 0, "R6 read of protected page");
    xlat(a | 32'h18, 1, "R6 hit write protected");
    wreg(2'd0, 64'h7_0001);
    xlat(32'hC0000000, 0, "R3 n7 base");
    xlat(32'hBFFFFFFF, 0, "R3 n7 below");

    prev = 32'hFFFF0000;
    for (int i = 0; i < 500; i++) begin
      int r;
      r = $urandom % 100;
      if (r < 4) wreg(2'd2, 64'($urandom));
      else if (r < 8) wreg(2'd1, {32'($urandom), 32'($urandom)});
      else if (r < 12) wreg(2'd0, 64'({$urandom % 8, 13'h0, 3'($urandom), ($urandom % 10) != 0}));
      else begin
        r = $urandom % 100;
        if (r < 40) a = {prev[31:13], 13'($urandom)};
        else if (r < 90) a = wbase(m_size) | ($urandom & ~wbase(m_size));
        else a = $urandom;
        prev = a;
        xlat(a, 1'($urandom), "random");
      end
    end
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule